// File: doc/BRIEF.md
# Page-Translated DMA Channel

This block is a single DMA channel that moves a burst of bytes between a peripheral and system memory, where the channel's logical address space is mapped onto physical memory through a translation table that itself lives in memory. Software programs a control/status word, a starting logical address, a remaining byte count, and the base and size of the translation table. A peripheral then raises a request carrying a byte length and a direction. The channel checks the request against its programming. It then walks the burst one page-sized piece at a time. For each piece it fetches a table entry over a read port, forms a physical address, and issues one transfer on a memory port.

No piece crosses a page boundary, and each piece is translated on its own. The walk ends in one of two ways. It completes, which raises a terminal-count flag. Or a table lookup falls outside the table, which raises a memory-error flag and leaves the count register holding the bytes still owed. A one-cycle done pulse marks the end of every accepted request.

Top module: `xdma_channel`

## Requirements
- R1: On accepting a request, the channel clears the status flags in the control word: terminal count (bit 8), memory error (bit 9) and address error (bit 10). Any flag the request then causes is set. The address-error flag reads 0 after every request.
- R2: If the enable bit (control bit 0) is 0, the request is rejected. Memory error is set, no table or memory access happens, and the count register is unchanged.
- R3: The control word's bit 1 set means memory-to-device. A request with `req_dev_to_mem`=1 needs bit 1 clear, and a request with `req_dev_to_mem`=0 needs bit 1 set. On a mismatch the request is rejected as in R2.
- R4: The number of bytes moved is the smaller of the requested length and the count register.
- R5: Each piece's length is the smaller of the bytes left in the current page (page size minus the in-page offset of the logical address) and the bytes left in the request. No memory transfer crosses a page.
- R6: The table index of a piece is the logical address divided by the page size. An index at or above the table limit divided by 8 sets memory error and stops the walk, with no access for that piece. Pieces already done stay done, and terminal count stays 0.
- R7: The table entry read for a piece is at table base + index × 8, with the top address bit forced to 0.
- R8: A piece's physical address is the 32-bit word returned by the table read, plus the logical address's in-page offset. `mem_write` equals the request direction: 1 means device to memory.
- R9: After each piece, the logical address advances by the piece length and the count register drops by the same amount. Terminal count is set once every clamped byte has been moved.
- R10: A request of length 0, or one made while the count register is 0, finishes with terminal count set and no table or memory access.
- R11: Every accepted request, whether rejected, failed or completed, ends with `req_done` high for exactly one cycle. By then the flags and count register are already final.
- R12: Register selects are 0 control, 1 start address, 2 count, 3 table base and 4 table limit. Writes are visible on `reg_rdata`, which is combinational from `reg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| req_valid | input | 1 | Peripheral request, accepted when the channel is idle |
| req_len | input | LEN_W (16) | Requested byte length |
| req_dev_to_mem | input | 1 | Requested direction, 1 = device to memory |
| req_done | output | 1 | One-cycle end-of-request pulse |
| tbl_rd_req | output | 1 | Table entry read request, held until acknowledged |
| tbl_rd_addr | output | ADDR_W (32) | Table entry address |
| tbl_rd_ack | input | 1 | Table read acknowledge with data |
| tbl_rd_data | input | ADDR_W (32) | Frame address word from the entry |
| mem_req | output | 1 | Data transfer request, held until acknowledged |
| mem_addr | output | ADDR_W (32) | Physical start address of the piece |
| mem_len | output | PAGE_BITS+1 | Byte length of the piece |
| mem_write | output | 1 | 1 = write memory (device to memory) |
| mem_ack | input | 1 | Data transfer acknowledge |

## Verification
A wrong piece length or offset shows up on `mem_addr` and `mem_len` at the first page crossing of a burst. A wrong index or limit comparison shows up as a table read that should not happen, or a missing one, in the same cycle the walk reaches the page concerned. An error in the count or flag update appears on `reg_rdata` no later than the done pulse of that request. Sweeping start offsets against lengths around the page size, with small pages, brings each of these out within a few dozen cycles of the request.

// File: rtl/xdma_pkg.sv
package xdma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_FETCH,
      ST_WAIT_ENT,
      ST_XFER,
      ST_WAIT_XFER,
      ST_DONE
   } xdma_state_e;

   localparam int REG_W = 32;

   localparam logic [2:0] SEL_CTRL   = 3'd0;
   localparam logic [2:0] SEL_ADDR   = 3'd1;
   localparam logic [2:0] SEL_COUNT  = 3'd2;
   localparam logic [2:0] SEL_TBASE  = 3'd3;
   localparam logic [2:0] SEL_TLIMIT = 3'd4;

   localparam int CTL_EN   = 0;
   localparam int CTL_M2D  = 1;
   localparam int CTL_TC   = 8;
   localparam int CTL_MERR = 9;
   localparam int CTL_AERR = 10;

endpackage

// File: rtl/xdma_regs.sv
module xdma_regs
   import xdma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              ctl_en,
   output logic              ctl_m2d,
   output logic [ADDR_W-1:0] start_addr,
   output logic [CNT_W-1:0]  count,
   output logic [ADDR_W-1:0] tbl_base,
   output logic [ADDR_W-1:0] tbl_limit,
   input  logic              clr_flags,
   input  logic              set_tc,
   input  logic              set_merr,
   input  logic              dec_en,
   input  logic [CNT_W-1:0]  dec_val
);

   initial begin
      if (ADDR_W > REG_W || ADDR_W < 8) $error("xdma_regs: ADDR_W out of range");
      if (CNT_W > REG_W || CNT_W < 4)   $error("xdma_regs: CNT_W out of range");
   end

   logic en_q, m2d_q, tc_q, merr_q, aerr_q;
   logic [ADDR_W-1:0] addr_q, base_q, lim_q;
   logic [CNT_W-1:0]  cnt_q;

   wire wr_ctrl  = reg_we && (reg_sel == SEL_CTRL);
   wire wr_count = reg_we && (reg_sel == SEL_COUNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         m2d_q  <= 1'b0;
         tc_q   <= 1'b0;
         merr_q <= 1'b0;
         aerr_q <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            en_q   <= reg_wdata[CTL_EN];
            m2d_q  <= reg_wdata[CTL_M2D];
            tc_q   <= reg_wdata[CTL_TC];
            merr_q <= reg_wdata[CTL_MERR];
            aerr_q <= reg_wdata[CTL_AERR];
         end
         if (clr_flags) begin
            tc_q   <= 1'b0;
            merr_q <= 1'b0;
            aerr_q <= 1'b0;
         end
         if (set_tc)   tc_q   <= 1'b1;
         if (set_merr) merr_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         base_q <= '0;
         lim_q  <= '0;
      end else if (reg_we) begin
         case (reg_sel)
            SEL_ADDR:   addr_q <= reg_wdata[ADDR_W-1:0];
            SEL_TBASE:  base_q <= reg_wdata[ADDR_W-1:0];
            SEL_TLIMIT: lim_q  <= reg_wdata[ADDR_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (dec_en)   cnt_q <= cnt_q - dec_val;
      else if (wr_count) cnt_q <= reg_wdata[CNT_W-1:0];
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         SEL_CTRL: begin
            reg_rdata[CTL_EN]   = en_q;
            reg_rdata[CTL_M2D]  = m2d_q;
            reg_rdata[CTL_TC]   = tc_q;
            reg_rdata[CTL_MERR] = merr_q;
            reg_rdata[CTL_AERR] = aerr_q;
         end
         SEL_ADDR:   reg_rdata = REG_W'(addr_q);
         SEL_COUNT:  reg_rdata = REG_W'(cnt_q);
         SEL_TBASE:  reg_rdata = REG_W'(base_q);
         SEL_TLIMIT: reg_rdata = REG_W'(lim_q);
         default:    reg_rdata = '0;
      endcase
   end

   assign ctl_en     = en_q;
   assign ctl_m2d    = m2d_q;
   assign start_addr = addr_q;
   assign count      = cnt_q;
   assign tbl_base   = base_q;
   assign tbl_limit  = lim_q;

   // R9: outside a software write, the count only ever falls
   p_count_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_count |=> cnt_q <= $past(cnt_q));

   // R1: a cleared-and-not-set address error flag reads zero next cycle
   p_aerr_cleared_r1: assert property (@(posedge clk) disable iff (!rst_n)
      clr_flags |=> !aerr_q);

endmodule

// File: rtl/xdma_piece_calc.sv
module xdma_piece_calc #(
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 32,
   parameter int PAGE_BITS = 12,
   parameter int ENT_BITS  = 3,
   parameter bit CLR_TOP   = 1'b1
) (
   input  logic [ADDR_W-1:0]  laddr,
   input  logic [CNT_W-1:0]   left,
   input  logic [ADDR_W-1:0]  tbl_base,
   input  logic [ADDR_W-1:0]  tbl_limit,
   output logic [PAGE_BITS:0] piece_len,
   output logic               index_ok,
   output logic [ADDR_W-1:0]  entry_addr
);

   localparam int PW = PAGE_BITS + 1;
   localparam logic [PW-1:0] PAGE_BYTES = PW'(1) << PAGE_BITS;

   initial begin
      if (PAGE_BITS < 4 || PAGE_BITS > 20) $error("xdma_piece_calc: PAGE_BITS out of range");
      if (ENT_BITS < 2 || ENT_BITS > 4)    $error("xdma_piece_calc: ENT_BITS out of range");
      if (CNT_W <= PAGE_BITS)              $error("xdma_piece_calc: CNT_W too small");
   end

   logic [PW-1:0]     in_page_off;
   logic [PW-1:0]     to_page_end;
   logic [ADDR_W-1:0] index;
   logic [ADDR_W-1:0] n_entries;
   logic [ADDR_W-1:0] raw_entry;

   assign in_page_off = PW'(laddr & ADDR_W'(PAGE_BYTES - 1'b1));
   assign to_page_end = PAGE_BYTES - in_page_off;

   always_comb begin
      if (left < CNT_W'(to_page_end)) piece_len = PW'(left);
      else                            piece_len = to_page_end;
   end

   assign index     = laddr >> PAGE_BITS;
   assign n_entries = tbl_limit >> ENT_BITS;
   assign index_ok  = index < n_entries;
   assign raw_entry = tbl_base + (index << ENT_BITS);

   generate
      if (CLR_TOP) begin : g_clr_top
         localparam logic [ADDR_W-1:0] KEEP = {1'b0, {(ADDR_W-1){1'b1}}};
         assign entry_addr = raw_entry & KEEP;
      end else begin : g_full
         assign entry_addr = raw_entry;
      end
   endgenerate

endmodule

// File: rtl/xdma_channel.sv
module xdma_channel
   import xdma_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 32,
   parameter int LEN_W     = 16,
   parameter int PAGE_BITS = 12,
   parameter int ENT_BITS  = 3,
   parameter bit CLR_TOP   = 1'b1,
   parameter bit JOIN_OR   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [2:0]           reg_sel,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic                 req_valid,
   input  logic [LEN_W-1:0]     req_len,
   input  logic                 req_dev_to_mem,
   output logic                 req_done,
   output logic                 tbl_rd_req,
   output logic [ADDR_W-1:0]    tbl_rd_addr,
   input  logic                 tbl_rd_ack,
   input  logic [ADDR_W-1:0]    tbl_rd_data,
   output logic                 mem_req,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [PAGE_BITS:0]   mem_len,
   output logic                 mem_write,
   input  logic                 mem_ack
);

   localparam int PW = PAGE_BITS + 1;
   localparam logic [PW-1:0] PAGE_BYTES = PW'(1) << PAGE_BITS;

   initial begin
      if (LEN_W > CNT_W) $error("xdma_channel: LEN_W must not exceed CNT_W");
   end

   xdma_state_e state;

   logic              ctl_en, ctl_m2d;
   logic [ADDR_W-1:0] start_addr, tbl_base, tbl_limit;
   logic [CNT_W-1:0]  count;
   logic              clr_flags, set_tc, set_merr, dec_en;

   logic [ADDR_W-1:0] work_addr;
   logic [CNT_W-1:0]  left_q;
   logic              dir_q;
   logic [ADDR_W-1:0] ent_q;
   logic [PW-1:0]     piece_q;
   logic [ADDR_W-1:0] frame_q;
   logic [ADDR_W-1:0] maddr_q;

   logic [PW-1:0]     piece_len;
   logic              index_ok;
   logic [ADDR_W-1:0] entry_addr;
   logic [ADDR_W-1:0] page_off;
   logic [ADDR_W-1:0] phys_addr;
   logic [CNT_W-1:0]  clamp_len;
   logic              req_ok;

   xdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .ctl_en     (ctl_en),
      .ctl_m2d    (ctl_m2d),
      .start_addr (start_addr),
      .count      (count),
      .tbl_base   (tbl_base),
      .tbl_limit  (tbl_limit),
      .clr_flags  (clr_flags),
      .set_tc     (set_tc),
      .set_merr   (set_merr),
      .dec_en     (dec_en),
      .dec_val    (CNT_W'(piece_q))
   );

   xdma_piece_calc #(
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .PAGE_BITS (PAGE_BITS),
      .ENT_BITS  (ENT_BITS),
      .CLR_TOP   (CLR_TOP)
   ) u_calc (
      .laddr      (work_addr),
      .left       (left_q),
      .tbl_base   (tbl_base),
      .tbl_limit  (tbl_limit),
      .piece_len  (piece_len),
      .index_ok   (index_ok),
      .entry_addr (entry_addr)
   );

   assign req_ok    = ctl_en && (req_dev_to_mem == !ctl_m2d);
   assign clamp_len = (CNT_W'(req_len) < count) ? CNT_W'(req_len) : count;
   assign page_off  = work_addr & ADDR_W'(PAGE_BYTES - 1'b1);

   generate
      if (JOIN_OR) begin : g_join_or
         assign phys_addr = frame_q | page_off;
      end else begin : g_join_add
         assign phys_addr = frame_q + page_off;
      end
   endgenerate

   assign clr_flags = (state == ST_IDLE) && req_valid;
   assign set_tc    = (state == ST_CHECK) && (left_q == '0);
   assign set_merr  = ((state == ST_IDLE) && req_valid && !req_ok) ||
                      ((state == ST_CHECK) && (left_q != '0) && !index_ok);
   assign dec_en    = (state == ST_WAIT_XFER) && mem_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         work_addr <= '0;
         left_q    <= '0;
         dir_q     <= 1'b0;
         ent_q     <= '0;
         piece_q   <= '0;
         frame_q   <= '0;
         maddr_q   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  dir_q     <= req_dev_to_mem;
                  work_addr <= start_addr;
                  left_q    <= req_ok ? clamp_len : '0;
                  state     <= req_ok ? ST_CHECK : ST_DONE;
               end
            end
            ST_CHECK: begin
               if (left_q == '0 || !index_ok) state <= ST_DONE;
               else                           state <= ST_FETCH;
            end
            ST_FETCH: begin
               ent_q   <= entry_addr;
               piece_q <= piece_len;
               state   <= ST_WAIT_ENT;
            end
            ST_WAIT_ENT: begin
               if (tbl_rd_ack) begin
                  frame_q <= tbl_rd_data;
                  state   <= ST_XFER;
               end
            end
            ST_XFER: begin
               maddr_q <= phys_addr;
               state   <= ST_WAIT_XFER;
            end
            ST_WAIT_XFER: begin
               if (mem_ack) begin
                  work_addr <= work_addr + ADDR_W'(piece_q);
                  left_q    <= left_q - CNT_W'(piece_q);
                  state     <= ST_CHECK;
               end
            end
            ST_DONE:  state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign req_done    = (state == ST_DONE);
   assign tbl_rd_req  = (state == ST_WAIT_ENT);
   assign tbl_rd_addr = ent_q;
   assign mem_req     = (state == ST_WAIT_XFER);
   assign mem_addr    = maddr_q;
   assign mem_len     = piece_q;
   assign mem_write   = dir_q;

   // R11: done lasts one cycle only
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> !req_done);

   // R7: a pending table read keeps its address until acknowledged
   p_tbl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_rd_req && !tbl_rd_ack) |=> (tbl_rd_req && $stable(tbl_rd_addr)));

   // R8: a pending data transfer keeps address, length and direction
   p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_len)
                                 && $stable(mem_write)));

   // R5: every transfer is non-empty and stays inside its page
   p_piece_in_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((mem_len != '0) &&
                   ((ADDR_W'(mem_len) + page_off) <= ADDR_W'(PAGE_BYTES))));

   // R8: table and data ports never request together
   p_one_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && tbl_rd_req));

   // R6: a table read is only issued for an index inside the table
   p_index_inside_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tbl_rd_req) |-> $past(index_ok));

endmodule

// File: tb/xdma_channel_tb.sv
module xdma_channel_tb;

   localparam int PB   = 6;
   localparam int PAGE = 1 << PB;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        req_valid = 1'b0;
   logic [15:0] req_len = '0;
   logic        req_dev_to_mem = 1'b0;
   logic        req_done;
   logic        tbl_rd_req;
   logic [31:0] tbl_rd_addr;
   logic        tbl_rd_ack = 1'b0;
   logic [31:0] tbl_rd_data = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic [PB:0] mem_len;
   logic        mem_write;
   logic        mem_ack = 1'b0;

   always #4 clk = ~clk;

   xdma_channel #(.PAGE_BITS(PB)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_len(req_len), .req_dev_to_mem(req_dev_to_mem),
      .req_done(req_done),
      .tbl_rd_req(tbl_rd_req), .tbl_rd_addr(tbl_rd_addr), .tbl_rd_ack(tbl_rd_ack),
      .tbl_rd_data(tbl_rd_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len), .mem_write(mem_write),
      .mem_ack(mem_ack)
   );

   int n_checks = 0;
   int n_fail   = 0;

   logic [31:0] log_taddr [16];
   logic [31:0] log_maddr [16];
   int          log_mlen  [16];
   logic        log_mwr   [16];
   int          n_tbl = 0;
   int          n_mem = 0;

   function automatic logic [31:0] frame_of(logic [31:0] a);
      return {a[25:0], 6'b0} ^ 32'h4000_0000;
   endfunction

   // memory and table responder: one-cycle acknowledge
   initial begin
      forever begin
         @(negedge clk);
         if (tbl_rd_ack) tbl_rd_ack = 1'b0;
         else if (tbl_rd_req) begin
            tbl_rd_ack  = 1'b1;
            tbl_rd_data = frame_of(tbl_rd_addr);
            if (n_tbl < 16) log_taddr[n_tbl] = tbl_rd_addr;
            n_tbl++;
         end
         if (mem_ack) mem_ack = 1'b0;
         else if (mem_req) begin
            mem_ack = 1'b1;
            if (n_mem < 16) begin
               log_maddr[n_mem] = mem_addr;
               log_mlen[n_mem]  = int'(mem_len);
               log_mwr[n_mem]   = mem_write;
            end
            n_mem++;
         end
      end
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", rq, what, act, exp);
      end
   endtask

   task automatic wreg(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rreg(input logic [2:0] sel, output logic [31:0] d);
      reg_sel = sel;
      #1;
      d = reg_rdata;
   endtask

   task automatic run_case(input bit en, input bit m2d, input logic [31:0] addr,
                           input logic [31:0] cnt, input logic [31:0] tbase,
                           input logic [31:0] tlim, input int len, input bit d2m);
      logic [31:0] exp_taddr [16];
      logic [31:0] exp_maddr [16];
      int          exp_mlen  [16];
      int          exp_n;
      bit          exp_tc, exp_merr;
      logic [31:0] exp_cnt, a, rd;
      int          left, off, p, idx, waited;
      bit          seen;

      // bench model of the walk
      exp_n = 0; exp_tc = 0; exp_merr = 0; exp_cnt = cnt;
      if (!en || (d2m == m2d)) exp_merr = 1;
      else begin
         left = (len < int'(cnt)) ? len : int'(cnt);
         a = addr;
         while (left > 0) begin
            off = int'(a % PAGE);
            p   = ((PAGE - off) < left) ? (PAGE - off) : left;
            idx = int'(a / PAGE);
            if (idx >= int'(tlim / 8)) begin exp_merr = 1; break; end
            exp_taddr[exp_n] = (tbase + 32'(idx) * 8) & 32'h7FFF_FFFF;
            exp_maddr[exp_n] = frame_of(exp_taddr[exp_n]) + 32'(off);
            exp_mlen[exp_n]  = p;
            exp_n++;
            a += 32'(p); left -= p; exp_cnt -= 32'(p);
         end
         if (left == 0) exp_tc = 1;
      end

      wreg(3'd1, addr);
      wreg(3'd2, cnt);
      wreg(3'd3, tbase);
      wreg(3'd4, tlim);
      wreg(3'd0, {21'd0, 3'b111, 6'd0, m2d, en});   // flags preset to 1
      n_tbl = 0; n_mem = 0;

      @(negedge clk);
      req_valid = 1'b1; req_len = 16'(len); req_dev_to_mem = d2m;
      @(negedge clk);
      req_valid = 1'b0;
      seen = 0; waited = 0;
      while (!seen && waited < 400) begin
         if (req_done) seen = 1;
         else begin @(negedge clk); waited++; end
      end
      chk(seen, "R11", "done pulse seen", 32'(seen), 32'd1);
      @(negedge clk);
      chk(!req_done, "R11", "done lasts one cycle", 32'(req_done), 32'd0);

      rreg(3'd0, rd);
      chk(rd[8] == exp_tc, exp_n == 0 && exp_tc ? "R10" : "R9", "terminal count flag",
          32'(rd[8]), 32'(exp_tc));
      chk(rd[9] == exp_merr, (!en) ? "R2" : (d2m == m2d) ? "R3" : "R6", "memory error flag",
          32'(rd[9]), 32'(exp_merr));
      chk(rd[10] == 1'b0, "R1", "address error cleared", 32'(rd[10]), 32'd0);
      rreg(3'd2, rd);
      chk(rd == exp_cnt, "R4", "count register after request", rd, exp_cnt);
      chk(n_tbl == exp_n, "R6", "table reads", 32'(n_tbl), 32'(exp_n));
      chk(n_mem == exp_n, "R5", "data transfers", 32'(n_mem), 32'(exp_n));
      for (int k = 0; k < exp_n && k < n_mem && k < n_tbl; k++) begin
         chk(log_taddr[k] == exp_taddr[k], "R7", "entry address", log_taddr[k], exp_taddr[k]);
         chk(log_maddr[k] == exp_maddr[k], "R8", "physical address", log_maddr[k], exp_maddr[k]);
         chk(log_mlen[k] == exp_mlen[k], "R5", "piece length",
             32'(log_mlen[k]), 32'(exp_mlen[k]));
         chk(log_mwr[k] == d2m, "R8", "transfer direction", 32'(log_mwr[k]), 32'(d2m));
      end
   endtask

   initial begin
      int wd = 0;
      while (wd < 200000) begin @(posedge clk); wd++; end
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int offs [4] = '{0, 1, 31, 63};
      int lens [8] = '{0, 1, 2, 63, 64, 65, 130, 200};
      int cnts [2] = '{300, 70};

      repeat (3) @(negedge clk);
      // reset state (R12)
      for (int s = 0; s < 5; s++) begin
         rreg(3'(s), rd);
         chk(rd == 32'd0, "R12", "register reset value", rd, 32'd0);
      end
      chk(!req_done && !tbl_rd_req && !mem_req, "R11", "outputs idle in reset",
          {29'd0, req_done, tbl_rd_req, mem_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // readback (R12)
      wreg(3'd3, 32'hA5A5_0F0F);
      rreg(3'd3, rd);
      chk(rd == 32'hA5A5_0F0F, "R12", "table base readback", rd, 32'hA5A5_0F0F);
      wreg(3'd4, 32'h0000_1234);
      rreg(3'd4, rd);
      chk(rd == 32'h0000_1234, "R12", "table limit readback", rd, 32'h0000_1234);

      // main sweep: offsets x lengths x counts, both directions (R4 R5 R7 R8 R9 R10)
      for (int c = 0; c < 2; c++)
         for (int o = 0; o < 4; o++)
            for (int l = 0; l < 8; l++)
               run_case(1'b1, l[0], 32'(3 * PAGE + offs[o]), 32'(cnts[c]),
                        32'h0000_0100, 32'h0000_1000, lens[l], !l[0]);

      // zero count register (R10)
      run_case(1'b1, 1'b0, 32'd10, 32'd0, 32'h100, 32'h1000, 50, 1'b1);
      // channel disabled (R2)
      run_case(1'b0, 1'b0, 32'd10, 32'd100, 32'h100, 32'h1000, 50, 1'b1);
      // direction mismatch both ways (R3)
      run_case(1'b1, 1'b1, 32'd10, 32'd100, 32'h100, 32'h1000, 50, 1'b1);
      run_case(1'b1, 1'b0, 32'd10, 32'd100, 32'h100, 32'h1000, 50, 1'b0);
      // table limit hit mid-walk and at first piece (R6)
      run_case(1'b1, 1'b0, 32'(3 * PAGE + 10), 32'd300, 32'h200, 32'd32, 150, 1'b1);
      run_case(1'b1, 1'b0, 32'(3 * PAGE + 10), 32'd300, 32'h200, 32'd31, 150, 1'b1);
      run_case(1'b1, 1'b1, 32'd0, 32'd300, 32'h200, 32'd0, 20, 1'b0);
      run_case(1'b1, 1'b0, 32'd0, 32'd300, 32'h200, 32'd8, 64, 1'b1);
      // top bit of entry address forced low (R7)
      run_case(1'b1, 1'b0, 32'(2 * PAGE + 5), 32'd500, 32'hFFFF_FF00, 32'h1000, 140, 1'b1);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule